// File: doc/BRIEF.md
# STS-1 Frame Alignment Monitor

This block receives an STS-1 line as a serial bit stream, one bit per clock, and finds where each frame starts. A frame starts with the two framing bytes 0xF6 and 0x28. While alignment is lost, the block compares a 16-bit sliding window against that word on every bit. When the window matches, it reloads its bit and byte counters to that position. Once it holds a candidate alignment, it looks for the framing word only at the one position where it should appear.

The aligned stream comes out as parallel bytes. Each byte has a one-cycle strobe and its index within the frame. A four-state quality machine counts consecutive good and bad framing words. Its state drives four level flags: in-frame, errored frame, severely errored frame and out of frame. Logic downstream uses the byte index to pick overhead bytes, and uses the flags for alarms.

Top module: `fam_align_mon`

## Requirements
- R1: While reset is applied and just after it, `oof_o` is high, the other three flags are low and `byte_vld_o` is low.
- R2: Exactly one of `in_frame_o`, `ef_o`, `sef_o`, `oof_o` is high in every cycle.
- R3: Bits arrive most significant bit first. When a byte's eighth bit is sampled, the next cycle shows that byte on `byte_o` and its frame index on `byte_idx_o`, and `byte_vld_o` is high for that one cycle only.
- R4: The byte index counts 0 to BYTES_PER_FRAME-1 (810 by default) and wraps to 0. Once aligned, the 0xF6 byte carries index 0 and the 0x28 byte carries index 1.
- R5: While out of frame with no candidate alignment, the block compares the last 16 bits against 0xF628 on every bit. On a match, the next bit is treated as byte 2, bit 0.
- R6: With a candidate alignment or in any other state, the block checks the framing word only where the byte-1 bit-7 position completes. A 0xF6 0x28 pair elsewhere in the frame does not move the alignment.
- R7: Two consecutive valid framing words give the in-frame state. A single valid word after out-of-frame or errored-frame leaves the state unchanged.
- R8: An invalid framing word clears the count of consecutive valid words. When this happens out of frame, the block drops the candidate alignment and hunts again.
- R9: A single invalid word while in frame changes nothing. Two consecutive invalid words give errored frame, and four give severely errored frame.
- R10: Twenty-four consecutive invalid framing words give the out-of-frame state.
- R11: A valid framing word clears the count of consecutive invalid words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit-rate clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_i | input | 1 | Serial line data |
| byte_o | output | 8 | Last completed byte |
| byte_vld_o | output | 1 | One-cycle strobe for `byte_o` |
| byte_idx_o | output | IDX_W | Frame index of `byte_o` |
| in_frame_o | output | 1 | In-frame state |
| ef_o | output | 1 | Errored-frame state |
| sef_o | output | 1 | Severely-errored-frame state |
| oof_o | output | 1 | Out-of-frame state |

## Verification
Assertions check the following on every cycle:
- one flag only is high;
- the byte strobe never lasts two cycles;
- the byte counter wraps and reloads correctly;
- no realignment happens outside the hunt;
- the state holds between framing checks;
- the in-frame and out-of-frame transitions happen at their exact counts.

Only the bench scenarios can show the rest. These are the order of state changes across frame sequences, the clearing of the valid and invalid counts, the refusal to follow an embedded framing word, and the byte values and indices after a lock at a new bit offset.

// File: rtl/fam_pkg.sv
package fam_pkg;
  typedef enum logic [1:0] {
    ST_IN  = 2'd0,
    ST_EF  = 2'd1,
    ST_SEF = 2'd2,
    ST_OOF = 2'd3
  } fam_state_e;

  localparam logic [15:0] FRAME_WORD = 16'hF628;
endpackage

// File: rtl/fam_shift.sv
module fam_shift #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         bit_i,
  output logic [W-1:0] win_o
);
  logic [W-2:0] sh_q;

  assign win_o = {sh_q, bit_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= win_o[W-2:0];
  end
endmodule

// File: rtl/fam_counter.sv
module fam_counter #(
  parameter int BYTES       = 810,
  parameter int IDX_W       = $clog2(BYTES),
  parameter int RELOAD_BYTE = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  output logic [IDX_W-1:0] byte_o,
  output logic             last_bit_o,
  output logic             chk_pos_o
);
  localparam logic [IDX_W-1:0] LAST  = IDX_W'(BYTES - 1);
  localparam logic [IDX_W-1:0] RLD   = IDX_W'(RELOAD_BYTE);
  localparam logic [IDX_W-1:0] CHK_B = IDX_W'(RELOAD_BYTE - 1);

  logic [2:0]       bit_q;
  logic [IDX_W-1:0] byte_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_q  <= '0;
      byte_q <= '0;
    end else if (load_i) begin
      bit_q  <= '0;
      byte_q <= RLD;
    end else begin
      bit_q <= bit_q + 3'd1;
      if (bit_q == 3'd7) byte_q <= (byte_q == LAST) ? '0 : byte_q + IDX_W'(1);
    end
  end

  assign byte_o     = byte_q;
  assign last_bit_o = (bit_q == 3'd7);
  assign chk_pos_o  = (bit_q == 3'd7) && (byte_q == CHK_B);

  // R5: a reload puts the next bit at byte 2, bit 0
  a_r5_reload_pos: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (bit_q == 3'd0 && byte_q == RLD));
  // R4: wrap after the last byte of the frame
  a_r4_byte_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && bit_q == 3'd7 && byte_q == LAST) |=> (byte_q == '0));
  a_r4_byte_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_q <= LAST);
endmodule

// File: rtl/fam_fsm.sv
module fam_fsm
  import fam_pkg::*;
#(
  parameter int IN_CNT  = 2,
  parameter int EF_CNT  = 2,
  parameter int SEF_CNT = 4,
  parameter int OOF_CNT = 24
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       match_i,
  input  logic       chk_pos_i,
  output logic       load_o,
  output fam_state_e state_o
);
  localparam int GW = $clog2(IN_CNT + 1);
  localparam int BW = $clog2(OOF_CNT + 1);

  fam_state_e    state_q, state_n;
  logic [GW-1:0] good_q, good_n;
  logic [BW-1:0] bad_q, bad_n;
  logic          hunt, chk_ev;

  // hunt only with no candidate alignment
  assign hunt   = (state_q == ST_OOF) && (good_q == '0);
  assign load_o = hunt && match_i;
  assign chk_ev = hunt ? match_i : chk_pos_i;

  always_comb begin
    state_n = state_q;
    good_n  = good_q;
    bad_n   = bad_q;
    if (chk_ev) begin
      if (match_i) begin
        bad_n  = '0;
        good_n = (good_q == GW'(IN_CNT)) ? good_q : good_q + GW'(1);
        if (good_n >= GW'(IN_CNT)) state_n = ST_IN;
      end else begin
        good_n = '0;
        bad_n  = (bad_q == BW'(OOF_CNT)) ? bad_q : bad_q + BW'(1);
        if (bad_n >= BW'(OOF_CNT))                         state_n = ST_OOF;
        else if (state_q == ST_OOF)                        state_n = ST_OOF;
        else if (bad_n >= BW'(SEF_CNT))                    state_n = ST_SEF;
        else if (bad_n >= BW'(EF_CNT) && state_q == ST_IN) state_n = ST_EF;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_OOF;
      good_q  <= '0;
      bad_q   <= '0;
    end else begin
      state_q <= state_n;
      good_q  <= good_n;
      bad_q   <= bad_n;
    end
  end

  assign state_o = state_q;

  // R7: the valid word completing the run enters in-frame
  a_r7_enter_in: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chk_ev && match_i && good_q == GW'(IN_CNT - 1)) |=> (state_q == ST_IN));
  // R10: the invalid word completing the run enters out-of-frame
  a_r10_enter_oof: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chk_ev && !match_i && bad_q == BW'(OOF_CNT - 1)) |=> (state_q == ST_OOF));
  // R8: an invalid word never leaves out-of-frame
  a_r8_oof_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_OOF && chk_ev && !match_i) |=> (state_q == ST_OOF && good_q == '0));
  // R6: the state moves only on a framing check
  a_r6_state_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !chk_ev |=> $stable(state_q));
endmodule

// File: rtl/fam_align_mon.sv
module fam_align_mon
  import fam_pkg::*;
#(
  parameter int BYTES_PER_FRAME = 810,
  parameter int IDX_W           = $clog2(BYTES_PER_FRAME),
  parameter int IN_CNT          = 2,
  parameter int EF_CNT          = 2,
  parameter int SEF_CNT         = 4,
  parameter int OOF_CNT         = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bit_i,
  output logic [7:0]       byte_o,
  output logic             byte_vld_o,
  output logic [IDX_W-1:0] byte_idx_o,
  output logic             in_frame_o,
  output logic             ef_o,
  output logic             sef_o,
  output logic             oof_o
);
  localparam int WIN_W = $bits(FRAME_WORD);

  logic [WIN_W-1:0] win;
  logic [IDX_W-1:0] byte_cnt;
  logic             last_bit, chk_pos, match, load;
  fam_state_e       state;

  fam_shift #(.W(WIN_W)) u_shift (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .bit_i (bit_i),
    .win_o (win)
  );

  fam_counter #(
    .BYTES      (BYTES_PER_FRAME),
    .IDX_W      (IDX_W),
    .RELOAD_BYTE(WIN_W / 8)
  ) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .byte_o    (byte_cnt),
    .last_bit_o(last_bit),
    .chk_pos_o (chk_pos)
  );

  assign match = (win == FRAME_WORD);

  fam_fsm #(
    .IN_CNT (IN_CNT),
    .EF_CNT (EF_CNT),
    .SEF_CNT(SEF_CNT),
    .OOF_CNT(OOF_CNT)
  ) u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .match_i  (match),
    .chk_pos_i(chk_pos),
    .load_o   (load),
    .state_o  (state)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      byte_vld_o <= 1'b0;
      byte_o     <= '0;
      byte_idx_o <= '0;
    end else begin
      byte_vld_o <= last_bit;
      if (last_bit) begin
        byte_o     <= win[7:0];
        byte_idx_o <= byte_cnt;
      end
    end
  end

  assign in_frame_o = (state == ST_IN);
  assign ef_o       = (state == ST_EF);
  assign sef_o      = (state == ST_SEF);
  assign oof_o      = (state == ST_OOF);

  // R2
  a_r2_one_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({in_frame_o, ef_o, sef_o, oof_o}) == 1);
  // R3
  a_r3_strobe_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_vld_o |=> !byte_vld_o);
  // R6: no realignment outside out-of-frame
  a_r6_no_relock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oof_o |-> !load);
endmodule

// File: tb/tb_fam_align_mon.sv
module tb_fam_align_mon;
  localparam int FB = 40;
  localparam int IW = $clog2(FB);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bit_in = 1'b0;
  logic [7:0]    byte_out;
  logic          byte_vld;
  logic [IW-1:0] byte_idx;
  logic          f_in, f_ef, f_sef, f_oof;

  int n_chk = 0;
  int n_err = 0;
  int n_bytes = 0;
  bit push_en = 1'b0;
  int q_val[$];
  int q_idx[$];

  fam_align_mon #(.BYTES_PER_FRAME(FB)) dut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .bit_i     (bit_in),
    .byte_o    (byte_out),
    .byte_vld_o(byte_vld),
    .byte_idx_o(byte_idx),
    .in_frame_o(f_in),
    .ef_o      (f_ef),
    .sef_o     (f_sef),
    .oof_o     (f_oof)
  );

  always #5 clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  // flags packed as {in_frame, ef, sef, oof}
  task automatic check_flags(input logic [3:0] exp, input string tag);
    logic [3:0] act;
    act = {f_in, f_ef, f_sef, f_oof};
    check(act == exp, tag, int'(act), int'(exp));
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk);
    bit_in = b;
  endtask

  task automatic send_byte(input logic [7:0] v, input int idx);
    for (int k = 7; k >= 0; k--) send_bit(v[k]);
    if (push_en) begin
      q_val.push_back(int'(v));
      q_idx.push_back(idx);
    end
  endtask

  // payload keeps its top two bits clear, so no false framing word appears
  task automatic send_frame(input logic [7:0] a1, input logic [7:0] a2, input int f,
                            input bit embed);
    send_byte(a1, 0);
    send_byte(a2, 1);
    for (int i = 2; i < FB; i++) begin
      if (embed && i == 10)      send_byte(8'hF6, i);
      else if (embed && i == 11) send_byte(8'h28, i);
      else                       send_byte(8'((f * 7 + i) & 63), i);
    end
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (rst_n && byte_vld && q_val.size() > 0) begin
        int ev, ei;
        ev = q_val.pop_front();
        ei = q_idx.pop_front();
        n_bytes++;
        check(int'(byte_out) == ev, "R3 byte value", int'(byte_out), ev);
        check(int'(byte_idx) == ei, "R4 byte index", int'(byte_idx), ei);
      end
    end
  end

  initial begin
    repeat (60000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=done");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    check_flags(4'b0001, "R1 reset flags");
    check(byte_vld == 1'b0, "R1 reset strobe", int'(byte_vld), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check_flags(4'b0001, "R1 after reset");

    for (int i = 0; i < 13; i++) send_bit(1'b0);
    send_frame(8'hF6, 8'h28, 1, 1'b0);
    check_flags(4'b0001, "R5 R7 first match stays oof");
    push_en = 1'b1;
    send_frame(8'hF6, 8'h28, 2, 1'b0);
    check_flags(4'b1000, "R7 two valid in frame");
    send_frame(8'hF6, 8'h28, 3, 1'b1);
    check_flags(4'b1000, "R6 embedded word ignored");
    send_frame(8'h76, 8'h28, 4, 1'b0);
    check_flags(4'b1000, "R9 single bad stays in frame");
    send_frame(8'hF6, 8'h28, 5, 1'b0);
    send_frame(8'hF6, 8'h20, 6, 1'b0);
    check_flags(4'b1000, "R11 valid cleared bad count");
    send_frame(8'h76, 8'h28, 7, 1'b0);
    check_flags(4'b0100, "R9 two bad errored");
    send_frame(8'hF6, 8'h28, 8, 1'b0);
    check_flags(4'b0100, "R7 one valid stays errored");
    send_frame(8'hF6, 8'h28, 9, 1'b0);
    check_flags(4'b1000, "R7 second valid in frame");
    send_frame(8'h76, 8'h28, 10, 1'b0);
    send_frame(8'hF6, 8'h20, 11, 1'b0);
    check_flags(4'b0100, "R9 errored again");
    send_frame(8'h76, 8'h28, 12, 1'b0);
    check_flags(4'b0100, "R9 three bad errored");
    send_frame(8'h76, 8'h28, 13, 1'b0);
    check_flags(4'b0010, "R9 four bad severe");
    for (int f = 14; f < 33; f++) send_frame(8'h76, 8'h28, f, 1'b0);
    check_flags(4'b0010, "R10 23 bad still severe");
    push_en = 1'b0;
    send_frame(8'h76, 8'h28, 33, 1'b0);
    check_flags(4'b0001, "R10 24 bad out of frame");
    repeat (4) @(negedge clk);
    check(q_val.size() == 0, "R3 all bytes strobed", q_val.size(), 0);

    for (int i = 0; i < 5; i++) send_bit(1'b0);
    send_frame(8'hF6, 8'h28, 34, 1'b0);
    check_flags(4'b0001, "R5 relock candidate");
    send_frame(8'hF6, 8'h20, 35, 1'b0);
    check_flags(4'b0001, "R8 bad drops candidate");
    send_frame(8'hF6, 8'h28, 36, 1'b0);
    check_flags(4'b0001, "R8 valid count was cleared");
    send_frame(8'hF6, 8'h28, 37, 1'b0);
    check_flags(4'b1000, "R7 relocked in frame");
    push_en = 1'b1;
    send_frame(8'hF6, 8'h28, 38, 1'b0);
    send_frame(8'hF6, 8'h28, 39, 1'b0);
    check_flags(4'b1000, "R5 new offset holds");
    repeat (4) @(negedge clk);
    check(q_val.size() == 0, "R3 R5 all bytes strobed", q_val.size(), 0);
    check(n_bytes == 33 * FB, "R3 strobe count", n_bytes, 33 * FB);
    report();
  end
endmodule